// File: doc/BRIEF.md
# SPI Serial Clock Generator with Selectable Divide Granularity

This block derives the serial clock of one SPI channel from a fixed reference clock of up to 48 MHz. That reference rate is also the fastest serial clock the channel may run at. A single granularity input picks the divide scheme. In coarse mode the reference is divided by a power of two, with the exponent taken from a 4-bit low divider field. In fine mode the divide ratio is any integer from 1 to 4096. That ratio is assembled from an 8-bit extension field (upper bits) and the same 4-bit low field (lower bits), plus one.

Besides the serial clock, the block emits single-cycle strobes in the reference domain. Two of them mark each rising and each falling transition of the serial clock. Two more tell the neighbouring shift logic when to launch the next bit and when to capture the incoming bit, following the clock polarity and phase inputs (SPI modes 0 to 3). A new ratio or mode is adopted only where a serial period ends, so a period in progress always runs to completion. While the channel is disabled, the counter is held at its start and the clock rests at its idle level.

Top module: `spi_sclk_gen`

## Requirements
- R1: While the channel enable is low, and for one reference cycle after it goes high, sclk_o equals pol_i and all four strobes are low. After enable drops, the same idle state returns one reference cycle later.
- R2: With fine_i = 0 the serial period is 2^clkd_i reference cycles.
- R3: With fine_i = 1 the serial period is N = {ext_i, clkd_i} + 1 reference cycles, with ext_i as the upper 8 bits.
- R4: With fine_i = 0 the value of ext_i has no effect on the serial clock or the strobes.
- R5: For N >= 2, each period starts with ceil(N/2) cycles at the active level (not pol_i), followed by floor(N/2) cycles at the idle level (pol_i).
- R6: For N = 1, sclk_o follows the reference clock: it is the inverse of pol_i while the reference clock is high and equals pol_i while it is low. Both edge strobes are high in every cycle.
- R7: A change of clkd_i, ext_i or fine_i while running takes effect only after the current period has completed with the old ratio.
- R8: rise_stb_o is high exactly in the reference cycles in which sclk_o has just gone from low to high, and fall_stb_o in those in which it has just gone from high to low. The leading edge comes in the first cycle of a period and the trailing edge in cycle ceil(N/2).
- R9: With pha_i = 0, capture_stb_o marks the leading edge and launch_stb_o the trailing edge. With pha_i = 1 the two are swapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Channel enable |
| fine_i | input | 1 | Granularity select: 0 power-of-two, 1 divide-by-N |
| clkd_i | input | 4 | Low divider field |
| ext_i | input | 8 | Extension divider field (fine mode only) |
| pol_i | input | 1 | Idle level of the serial clock |
| pha_i | input | 1 | Capture on leading (0) or trailing (1) edge |
| sclk_o | output | 1 | Serial clock |
| rise_stb_o | output | 1 | Serial clock rising-edge strobe |
| fall_stb_o | output | 1 | Serial clock falling-edge strobe |
| launch_stb_o | output | 1 | Strobe to shift out the next bit |
| capture_stb_o | output | 1 | Strobe to sample the incoming bit |

## Verification
Several properties are checked on every reference cycle. The idle level and silent strobes after a disabled cycle are one. So are the bound on the period counter, the rule that the active ratio only changes at the start of a period, the exclusion of simultaneous rise and fall outside pass-through, and the separation of launch from capture. Other behaviour only shows up across whole runs with known settings. This covers the exact period length in each mode, the odd-ratio duty split, the deferred adoption of a changed ratio, the pass-through waveform at N = 1, and the coarse mode ignoring the extension field. The bench checks these against a cycle model.

// File: rtl/spi_sclk_gen_pkg.sv
package spi_sclk_gen_pkg;

  typedef enum logic {
    GRAN_POW2   = 1'b0,
    GRAN_LINEAR = 1'b1
  } gran_e;

  typedef struct packed {
    logic lead;
    logic trail;
  } sclk_edge_t;

endpackage

// File: rtl/spi_sclk_ratio.sv
module spi_sclk_ratio
  import spi_sclk_gen_pkg::*;
#(
  parameter int CLKD_W = 4,
  parameter int EXT_W  = 8,
  parameter int CNT_W  = 16
) (
  input  logic              fine_i,
  input  logic [CLKD_W-1:0] clkd_i,
  input  logic [EXT_W-1:0]  ext_i,
  output logic [CNT_W-1:0]  ratio_o,
  output logic [CNT_W-1:0]  half_o
);
  localparam int FINE_W = CLKD_W + EXT_W;

  logic [CNT_W-1:0] pow2_ratio;
  logic [CNT_W-1:0] lin_ratio;
  logic [FINE_W-1:0] lin_code;

  assign lin_code   = {ext_i, clkd_i};
  assign pow2_ratio = CNT_W'(1) << clkd_i;
  assign lin_ratio  = CNT_W'(lin_code) + CNT_W'(1);

  always_comb begin
    unique case (gran_e'(fine_i))
      GRAN_LINEAR: ratio_o = lin_ratio;
      default:     ratio_o = pow2_ratio;
    endcase
  end

  // active phase length: ceil(N/2)
  assign half_o = (ratio_o >> 1) + CNT_W'(ratio_o[0]);

endmodule

// File: rtl/spi_sclk_count.sv
module spi_sclk_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] ratio_req_i,
  input  logic [CNT_W-1:0] half_req_i,
  output logic             run_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] ratio_o,
  output logic [CNT_W-1:0] half_o
);
  logic at_end;

  assign at_end = (cnt_o == ratio_o - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_o   <= 1'b0;
      cnt_o   <= '0;
      ratio_o <= CNT_W'(1);
      half_o  <= CNT_W'(1);
    end else if (!en_i) begin
      run_o <= 1'b0;
      cnt_o <= '0;
    end else if (!run_o || at_end) begin
      // period start: adopt the requested setting
      run_o   <= 1'b1;
      cnt_o   <= '0;
      ratio_o <= ratio_req_i;
      half_o  <= half_req_i;
    end else begin
      cnt_o <= cnt_o + CNT_W'(1);
    end
  end

endmodule

// File: rtl/spi_sclk_wave.sv
module spi_sclk_wave
  import spi_sclk_gen_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] ratio_i,
  input  logic [CNT_W-1:0] half_i,
  input  logic             pol_i,
  input  logic             pha_i,
  output logic             sclk_o,
  output logic             rise_o,
  output logic             fall_o,
  output logic             launch_o,
  output logic             capture_o
);
  logic       pass;
  logic       active;
  logic       level;
  sclk_edge_t edg;

  assign pass   = run_i && (ratio_i == CNT_W'(1));
  assign active = cnt_i < half_i;
  assign level  = run_i ? (pol_i ^ active) : pol_i;

  assign edg.lead  = run_i && (cnt_i == '0);
  assign edg.trail = run_i && (pass || (cnt_i == half_i));

  always_comb begin
    if (pass) sclk_o = pol_i ^ clk_i;
    else      sclk_o = level;
  end

  always_comb begin
    if (pol_i) begin
      rise_o = edg.trail;
      fall_o = edg.lead;
    end else begin
      rise_o = edg.lead;
      fall_o = edg.trail;
    end
    if (pha_i) begin
      capture_o = edg.trail;
      launch_o  = edg.lead;
    end else begin
      capture_o = edg.lead;
      launch_o  = edg.trail;
    end
  end

endmodule

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen #(
  parameter int CLKD_W = 4,
  parameter int EXT_W  = 8
) (
  input  logic              clk_ref_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              fine_i,
  input  logic [CLKD_W-1:0] clkd_i,
  input  logic [EXT_W-1:0]  ext_i,
  input  logic              pol_i,
  input  logic              pha_i,
  output logic              sclk_o,
  output logic              rise_stb_o,
  output logic              fall_stb_o,
  output logic              launch_stb_o,
  output logic              capture_stb_o
);
  localparam int POW2_BITS = (1 << CLKD_W);
  localparam int LIN_BITS  = CLKD_W + EXT_W + 1;
  localparam int CNT_W     = (POW2_BITS > LIN_BITS) ? POW2_BITS : LIN_BITS;

  logic [CNT_W-1:0] ratio_req, half_req;
  logic [CNT_W-1:0] cnt_q, ratio_q, half_q;
  logic             run_q;

  spi_sclk_ratio #(.CLKD_W(CLKD_W), .EXT_W(EXT_W), .CNT_W(CNT_W)) ratio_i (
    .fine_i  (fine_i),
    .clkd_i  (clkd_i),
    .ext_i   (ext_i),
    .ratio_o (ratio_req),
    .half_o  (half_req)
  );

  spi_sclk_count #(.CNT_W(CNT_W)) count_i (
    .clk_i       (clk_ref_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .ratio_req_i (ratio_req),
    .half_req_i  (half_req),
    .run_o       (run_q),
    .cnt_o       (cnt_q),
    .ratio_o     (ratio_q),
    .half_o      (half_q)
  );

  spi_sclk_wave #(.CNT_W(CNT_W)) wave_i (
    .clk_i     (clk_ref_i),
    .run_i     (run_q),
    .cnt_i     (cnt_q),
    .ratio_i   (ratio_q),
    .half_i    (half_q),
    .pol_i     (pol_i),
    .pha_i     (pha_i),
    .sclk_o    (sclk_o),
    .rise_o    (rise_stb_o),
    .fall_o    (fall_stb_o),
    .launch_o  (launch_stb_o),
    .capture_o (capture_stb_o)
  );

endmodule

// File: rtl/spi_sclk_gen_chk.sv
module spi_sclk_gen_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             pol_i,
  input logic             sclk_i,
  input logic             rise_i,
  input logic             fall_i,
  input logic             launch_i,
  input logic             capture_i,
  input logic             run_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] ratio_i
);
  // R1
  idle_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(en_i) |-> (sclk_i == pol_i) && !rise_i && !fall_i && !launch_i && !capture_i);

  // R5
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_i < ratio_i));

  // R7
  ratio_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i) && (cnt_i != '0)) |-> $stable(ratio_i));

  // R8
  edge_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ratio_i != CNT_W'(1)) |-> !(rise_i && fall_i));

  // R9
  phase_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ratio_i != CNT_W'(1)) |-> $onehot0({launch_i, capture_i}));

endmodule

bind spi_sclk_gen spi_sclk_gen_chk #(.CNT_W(CNT_W)) chk_i (
  .clk_i     (clk_ref_i),
  .rst_ni    (rst_ni),
  .en_i      (en_i),
  .pol_i     (pol_i),
  .sclk_i    (sclk_o),
  .rise_i    (rise_stb_o),
  .fall_i    (fall_stb_o),
  .launch_i  (launch_stb_o),
  .capture_i (capture_stb_o),
  .run_i     (run_q),
  .cnt_i     (cnt_q),
  .ratio_i   (ratio_q)
);

// File: tb/spi_sclk_gen_tb.sv
module spi_sclk_gen_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, en, fine, pol, pha;
  logic [3:0] clkd;
  logic [7:0] ext;
  logic       sclk, rise, fall, launch, capture;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  spi_sclk_gen dut_i (
    .clk_ref_i(clk), .rst_ni(rst_n), .en_i(en), .fine_i(fine),
    .clkd_i(clkd), .ext_i(ext), .pol_i(pol), .pha_i(pha),
    .sclk_o(sclk), .rise_stb_o(rise), .fall_stb_o(fall),
    .launch_stb_o(launch), .capture_stb_o(capture)
  );

  function automatic int exp_ratio(bit f, logic [3:0] cd, logic [7:0] ex);
    if (f) return int'({ex, cd}) + 1;
    return 1 << cd;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic chk_idle(string req);
    chk(sclk == pol, req, "idle sclk", int'(sclk), int'(pol));
    chk({rise, fall, launch, capture} == 4'b0, req, "idle strobes",
        int'({rise, fall, launch, capture}), 0);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic run_cfg(bit f, logic [3:0] cd, logic [7:0] ex, bit po, bit ph,
                         int nsamp, int chg_at, bit f2, logic [3:0] cd2,
                         logic [7:0] ex2, string req);
    int cur_n, p, half;
    bit lead, trail, exps;
    logic [3:0] es;
    @(negedge clk);
    en = 1'b0; fine = f; clkd = cd; ext = ex; pol = po; pha = ph;
    @(negedge clk);
    chk_idle("R1");
    en = 1'b1;
    cur_n = exp_ratio(f, cd, ex);
    p = 0;
    for (int k = 0; k < nsamp; k++) begin
      @(negedge clk);
      half  = (cur_n + 1) / 2;
      lead  = (p == 0);
      trail = (cur_n == 1) ? 1'b1 : (p == half);
      exps  = (cur_n == 1) ? po : (po ^ (p < half));
      // order: rise, fall, launch, capture
      es = {po ? trail : lead, po ? lead : trail, ph ? lead : trail, ph ? trail : lead};
      chk(sclk == exps, req, "sclk", int'(sclk), int'(exps));
      chk({rise, fall, launch, capture} == es, "R8 R9", "strobes",
          int'({rise, fall, launch, capture}), int'(es));
      if (k == chg_at) begin
        fine = f2; clkd = cd2; ext = ex2;
      end
      if (p == cur_n - 1) begin
        p = 0;
        cur_n = exp_ratio(fine, clkd, ext);
      end else begin
        p++;
      end
    end
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk_idle("R1");
  endtask

  task automatic pass_test(bit po);
    @(negedge clk);
    en = 1'b0; fine = 1'b1; clkd = 4'd0; ext = 8'd0; pol = po; pha = 1'b0;
    @(negedge clk);
    en = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      @(posedge clk); #1;
      chk(sclk == !po, "R6", "pass sclk high phase", int'(sclk), int'(!po));
      chk(rise && fall, "R6", "pass both edges", int'({rise, fall}), 3);
      @(negedge clk); #1;
      chk(sclk == po, "R6", "pass sclk low phase", int'(sclk), int'(po));
    end
    en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk_idle("R1");
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      report();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; en = 1'b0; fine = 1'b0; clkd = 4'd0; ext = 8'd0;
    pol = 1'b0; pha = 1'b0;
    repeat (3) @(negedge clk);
    chk_idle("R1");
    pol = 1'b1;
    @(negedge clk);
    chk_idle("R1");
    rst_n = 1'b1;

    // R2 R4: coarse divide by 8 with a non-zero extension field
    run_cfg(1'b0, 4'd3, 8'hA5, 1'b0, 1'b0, 24, -1, 1'b0, 4'd0, 8'd0, "R2 R4 R5");
    // R3 R5: odd fine ratio 5, inverted polarity, trailing capture
    run_cfg(1'b1, 4'd4, 8'h00, 1'b1, 1'b1, 20, -1, 1'b0, 4'd0, 8'd0, "R3 R5");
    // R3: N = 2
    run_cfg(1'b1, 4'd1, 8'h00, 1'b0, 1'b1, 10, -1, 1'b0, 4'd0, 8'd0, "R3 R5");
    // R3: ratio 32 from both fields
    run_cfg(1'b1, 4'hF, 8'h01, 1'b0, 1'b0, 70, -1, 1'b0, 4'd0, 8'd0, "R3 R5");
    // R3: largest fine ratio 4096
    run_cfg(1'b1, 4'hF, 8'hFF, 1'b1, 1'b0, 8200, -1, 1'b0, 4'd0, 8'd0, "R3");
    // R2: coarse 1024
    run_cfg(1'b0, 4'd10, 8'h3C, 1'b0, 1'b1, 2060, -1, 1'b0, 4'd0, 8'd0, "R2 R4");
    // R7: fine 6 changed mid-period to fine 3
    run_cfg(1'b1, 4'd5, 8'h00, 1'b0, 1'b0, 20, 2, 1'b1, 4'd2, 8'h00, "R7");
    // R7: coarse 4 changed to fine 7
    run_cfg(1'b0, 4'd2, 8'h00, 1'b1, 1'b1, 25, 1, 1'b1, 4'd6, 8'h00, "R7");
    // R6: pass-through at N = 1, both polarities
    pass_test(1'b0);
    pass_test(1'b1);
    // R6 R7: switch from N = 1 to N = 3
    run_cfg(1'b1, 4'd0, 8'h00, 1'b0, 1'b0, 12, 2, 1'b1, 4'd2, 8'h00, "R6 R7");

    // random mix
    for (int it = 0; it < 40; it++) begin
      bit f, f2, po, ph;
      logic [3:0] cd, cd2;
      logic [7:0] ex, ex2;
      int n, chg;
      f  = 1'($urandom());
      po = 1'($urandom());
      ph = 1'($urandom());
      ex = 8'($urandom());
      cd = f ? 4'($urandom()) : 4'($urandom_range(0, 6));
      if (f) ex = 8'($urandom_range(0, 3));
      n = exp_ratio(f, cd, ex);
      f2  = 1'($urandom());
      ex2 = f2 ? 8'($urandom_range(0, 2)) : 8'($urandom());
      cd2 = f2 ? 4'($urandom()) : 4'($urandom_range(0, 5));
      chg = $urandom_range(0, n);
      run_cfg(f, cd, ex, po, ph, 2 * n + 70, chg, f2, cd2, ex2,
              f ? "R3 R5 R7" : "R2 R4 R5 R7");
    end

    done = 1'b1;
    report();
    $finish;
  end

endmodule